// File: doc/BRIEF.md
# Byte-Wide Indirect Register Access Sequencer

This block is a bus master for a peripheral that has 16-bit internal registers but only an 8-bit data bus. The peripheral reaches its registers through a two-byte pointer port and a two-byte data port. A host asks for one 16-bit register read or write. The sequencer turns that request into a series of strobed byte cycles on a 4-bit port address and an 8-bit data bus. The data bus is split into an output byte, an input byte and an output enable.

The peripheral's pointer does not advance by itself. Every access therefore writes both pointer bytes first and then moves the two data bytes. The host can also ask for a connection check. This check reads back the two pointer bytes and reports a live device when the upper nibble of the high byte is 3.

Strobe width and recovery gap are parameters counted in clock cycles. There is one setup cycle and one hold cycle around every strobe. In those cycles the address enable is high and the address and data do not change. The design is a single module. Its assertions sit in a bound checker.

Top module: `ibus_reg_seq`

## Requirements
- R1: While reset is held, busy, done, dev_aen, dev_ior, dev_iow and dev_doe are all 0.
- R2: A write request (req_write=1, req_check=0) runs four write byte cycles on port addresses 0xA, 0xB, 0xC, 0xD in that order. They carry, in turn, address bits 7:0, address bits 15:8, data bits 7:0 and data bits 15:8.
- R3: A read request (req_write=0, req_check=0) writes the address low byte to 0xA and the address high byte to 0xB. It then reads port 0xC into rdata[7:0] and port 0xD into rdata[15:8].
- R4: A check request (req_check=1) runs two read byte cycles, on 0xA and then 0xB, and sets rdata to {byte from 0xB, byte from 0xA}. When done is high, check_ok is 1 exactly when rdata[15:12] equals 4'h3.
- R5: Every read or write access writes both pointer bytes, even when the same register address is used by consecutive accesses.
- R6: A strobe (dev_ior or dev_iow) is only high while dev_aen is high. dev_aen goes high one cycle before a strobe rises and stays high one cycle after it falls. dev_addr and the driven dev_dout stay constant while dev_aen stays high.
- R7: Each strobe is high for exactly STROBE_CYC cycles. dev_aen is low for at least RECOVER_CYC cycles between byte cycles.
- R8: dev_doe is high during write byte cycles only. It is never high together with dev_ior.
- R9: A request accepted at a clock edge raises done for exactly one cycle, N*(STROBE_CYC+RECOVER_CYC+2) cycles later, with N=4 for read/write and N=2 for check. busy is high from acceptance until done, and low while done is high.
- R10: A request presented while busy is high is ignored: no extra byte cycles run and the current access finishes unchanged.
- R11: When req_check and req_write are both 1, the request is a check and no byte cycle is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_check | input | 1 | 1 = connection check (wins over req_write) |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Register write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read or check result |
| check_ok | output | 1 | Connection check result, valid with done |
| dev_addr | output | 4 | Device port address |
| dev_dout | output | 8 | Device data byte driven out |
| dev_din | input | 8 | Device data byte read in |
| dev_doe | output | 1 | Output enable for dev_dout |
| dev_aen | output | 1 | Address enable, active high |
| dev_ior | output | 1 | I/O read strobe, active high |
| dev_iow | output | 1 | I/O write strobe, active high |

## Verification
A bench model of the peripheral holds a pointer and a small register file. Random writes, reads and checks run against it with random addresses and data. A byte swap, a wrong port offset or a missing pointer rewrite then shows up as a readback that differs from a shadow copy kept in the bench. Directed checks set pointer values whose upper nibble is 3, 2 or 4, which separates a correct nibble compare from an off-by-one or a wrong bit field. The directed checks also set both request flags at once, and hold junk requests while busy, to show that check has priority and that busy blocks new requests. A bus monitor measures strobe width, setup, hold, recovery gap and output-enable overlap on every byte cycle.

// File: rtl/ibus_reg_seq.sv
module ibus_reg_seq #(
  parameter int STROBE_CYC  = 2,
  parameter int RECOVER_CYC = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_check,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        check_ok,
  output logic [3:0]  dev_addr,
  output logic [7:0]  dev_dout,
  input  logic [7:0]  dev_din,
  output logic        dev_doe,
  output logic        dev_aen,
  output logic        dev_ior,
  output logic        dev_iow
);

  localparam int CNT_MAX = (STROBE_CYC > RECOVER_CYC) ? STROBE_CYC : RECOVER_CYC;
  localparam int CW = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
  localparam logic [3:0] PTR_LO = 4'hA;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_GAP} phase_t;

  phase_t      phase;
  logic [1:0]  idx;
  logic [CW-1:0] cnt;
  logic        op_check, op_write, done_q;
  logic [15:0] addr_q, wdata_q, rdata_q;
  logic [7:0]  byte_out;

  wire last_byte = op_check ? (idx == 2'd1) : (idx == 2'd3);
  wire byte_wr   = !op_check && (op_write || !idx[1]);
  wire on_bus    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  always_comb begin
    case (idx)
      2'd0:    byte_out = addr_q[7:0];
      2'd1:    byte_out = addr_q[15:8];
      2'd2:    byte_out = wdata_q[7:0];
      default: byte_out = wdata_q[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      idx      <= 2'd0;
      cnt      <= '0;
      op_check <= 1'b0;
      op_write <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: if (req_valid) begin
          op_check <= req_check;
          op_write <= req_write & ~req_check;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          idx      <= 2'd0;
          cnt      <= '0;
          phase    <= PH_SETUP;
        end
        PH_SETUP: phase <= PH_STROBE;
        PH_STROBE: begin
          if (cnt == CW'(STROBE_CYC - 1)) begin
            cnt   <= '0;
            phase <= PH_HOLD;
            if (!byte_wr) begin
              if (idx[0]) rdata_q[15:8] <= dev_din;
              else        rdata_q[7:0]  <= dev_din;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: phase <= PH_GAP;
        default: begin
          if (cnt == CW'(RECOVER_CYC - 1)) begin
            cnt <= '0;
            if (last_byte) begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              idx   <= idx + 2'd1;
              phase <= PH_SETUP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy     = (phase != PH_IDLE);
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign check_ok = op_check && (rdata_q[15:12] == 4'h3);
  assign dev_addr = PTR_LO + {2'b00, idx};
  assign dev_aen  = on_bus;
  assign dev_doe  = on_bus && byte_wr;
  assign dev_dout = dev_doe ? byte_out : 8'h00;
  assign dev_ior  = (phase == PH_STROBE) && !byte_wr;
  assign dev_iow  = (phase == PH_STROBE) && byte_wr;

endmodule

// File: rtl/ibus_reg_seq_chk.sv
module ibus_reg_seq_chk #(
  parameter int STROBE_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [3:0] dev_addr,
  input logic       dev_doe,
  input logic       dev_aen,
  input logic       dev_ior,
  input logic       dev_iow
);

  logic [31:0] width_q;
  wire strobe = dev_ior | dev_iow;

  always_ff @(posedge clk) begin
    if (!rst_n)      width_q <= '0;
    else if (strobe) width_q <= width_q + 1;
    else             width_q <= '0;
  end

  assert_strobe_in_aen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> dev_aen);
  assert_strobe_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(dev_aen));
  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> dev_aen);
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_aen && $past(dev_aen)) |-> $stable(dev_addr));
  assert_strobe_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> (width_q == STROBE_CYC));
  assert_no_read_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ior |-> (!dev_doe && !dev_iow));
  assert_write_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_iow |-> dev_doe);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind ibus_reg_seq ibus_reg_seq_chk #(.STROBE_CYC(STROBE_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .dev_addr(dev_addr),
  .dev_doe(dev_doe), .dev_aen(dev_aen), .dev_ior(dev_ior), .dev_iow(dev_iow)
);

// File: tb/ibus_reg_seq_tb_top.sv
module ibus_reg_seq_tb_top;
  localparam int S = 2;
  localparam int R = 1;
  localparam int L = S + R + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_check = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic busy, done, check_ok, dev_doe, dev_aen, dev_ior, dev_iow;
  logic [15:0] rdata;
  logic [3:0] dev_addr;
  logic [7:0] dev_dout, dev_din;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ibus_reg_seq #(.STROBE_CYC(S), .RECOVER_CYC(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_check(req_check), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .check_ok(check_ok),
    .dev_addr(dev_addr), .dev_dout(dev_dout), .dev_din(dev_din),
    .dev_doe(dev_doe), .dev_aen(dev_aen), .dev_ior(dev_ior), .dev_iow(dev_iow));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // peripheral model
  logic [15:0] ptr;
  logic [15:0] dmem [64];
  initial for (int i = 0; i < 64; i++) dmem[i] = '0;

  assign dev_din = !dev_ior ? 8'h00 :
                   (dev_addr == 4'hA) ? ptr[7:0] :
                   (dev_addr == 4'hB) ? ptr[15:8] :
                   (dev_addr == 4'hC) ? dmem[ptr[5:0]][7:0] :
                   (dev_addr == 4'hD) ? dmem[ptr[5:0]][15:8] : 8'hEE;

  always @(negedge clk) begin
    if (!rst_n) ptr <= 16'h3000;
    else if (dev_iow && dev_aen) begin
      case (dev_addr)
        4'hA: ptr[7:0] <= dev_dout;
        4'hB: ptr[15:8] <= dev_dout;
        4'hC: dmem[ptr[5:0]][7:0] <= dev_dout;
        4'hD: dmem[ptr[5:0]][15:8] <= dev_dout;
        default: ;
      endcase
    end
  end

  // bus monitor
  int ev_total = 0;
  logic [3:0] ev_addr [64];
  logic       ev_wr [64];
  logic [7:0] ev_data [64];
  logic prev_aen = 0, prev_str = 0, prev_doe = 0;
  logic [3:0] prev_addr = '0;
  logic [7:0] prev_dout = '0;
  int swidth = 0, lowrun = 100;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic str = dev_ior | dev_iow;
      if (str && !dev_aen) chk(0, "R6 strobe without aen", 0, 1);
      if (dev_aen && prev_aen && dev_addr != prev_addr) chk(0, "R6 addr moved", dev_addr, prev_addr);
      if (dev_doe && prev_doe && prev_aen && dev_aen && dev_dout != prev_dout)
        chk(0, "R6 dout moved", dev_dout, prev_dout);
      if (str && !prev_str) begin
        chk(prev_aen, "R6 setup cycle", prev_aen, 1);
        chk(dev_iow ? dev_doe : !dev_doe, "R8 output enable", dev_doe, dev_iow);
        ev_addr[ev_total % 64] = dev_addr;
        ev_wr[ev_total % 64]   = dev_iow;
        ev_data[ev_total % 64] = dev_iow ? dev_dout : dev_din;
        ev_total++;
      end
      if (!str && prev_str) begin
        chk(dev_aen, "R6 hold cycle", dev_aen, 1);
        chk(swidth == S, "R7 strobe width", swidth, S);
      end
      if (dev_aen && !prev_aen) chk(lowrun >= R, "R7 recovery gap", lowrun, R);
      if (dev_doe && dev_ior) chk(0, "R8 doe with read", 1, 0);
      swidth = str ? swidth + 1 : 0;
      lowrun = dev_aen ? 0 : lowrun + 1;
      prev_str = str;
    end
    prev_aen = dev_aen; prev_addr = dev_addr; prev_doe = dev_doe; prev_dout = dev_dout;
  end

  function automatic int exp_n(input bit c);
    return c ? 2 : 4;
  endfunction

  function automatic logic [7:0] exp_byte(input int i, input logic [15:0] a, input logic [15:0] d);
    case (i)
      0: return a[7:0];
      1: return a[15:8];
      2: return d[7:0];
      default: return d[15:8];
    endcase
  endfunction

  task automatic run(input bit w, input bit c, input logic [15:0] a, input logic [15:0] d,
                     input int junk, output logic [15:0] rd, output logic ok);
    int start, n, ne;
    bit is_chk;
    @(negedge clk);
    start = ev_total;
    req_valid = 1; req_write = w; req_check = c; req_addr = a; req_wdata = d;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n <= junk) begin
        req_valid = 1; req_write = ~w; req_check = ~c; req_addr = ~a; req_wdata = ~d;
      end else req_valid = 0;
      if (done) break;
      if (!busy) chk(0, "R9 busy low before done", n, 0);
      if (n > 500) begin chk(0, "R9 done never came", n, 0); break; end
    end
    is_chk = c;
    chk(!busy, "R9 busy low with done", busy, 0);
    chk(n == exp_n(is_chk) * L + 1, "R9 latency", n, exp_n(is_chk) * L + 1);
    rd = rdata; ok = check_ok;
    ne = ev_total - start;
    chk(ne == exp_n(is_chk), "R10 byte cycle count", ne, exp_n(is_chk));
    for (int i = 0; i < exp_n(is_chk) && i < ne; i++) begin
      automatic int k = (start + i) % 64;
      automatic bit ewr = !is_chk && (w || i < 2);
      chk(ev_addr[k] == 4'hA + 4'(i), is_chk ? "R4 port order" : (w ? "R2 port order" : "R3 port order"), ev_addr[k], 4'hA + i);
      chk(ev_wr[k] == ewr, is_chk ? "R11 cycle direction" : "R5 cycle direction", ev_wr[k], ewr);
      if (ewr) chk(ev_data[k] == exp_byte(i, a, d), i < 2 ? "R5 pointer byte" : "R2 data byte", ev_data[k], exp_byte(i, a, d));
    end
  endtask

  logic [15:0] shadow [64];
  logic [15:0] exp_ptr;
  logic [15:0] rd;
  logic ok;

  task automatic do_check(input logic [15:0] eptr, input string tag);
    run(0, 1, 16'h0000, 16'h0000, 0, rd, ok);
    chk(rd == eptr, {tag, " R4 check data"}, rd, eptr);
    chk(ok == (eptr[15:12] == 4'h3), {tag, " R4 check_ok"}, ok, eptr[15:12] == 4'h3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = '0;
    void'($urandom(32'h1BADB002));
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    chk(!dev_aen && !dev_ior && !dev_iow && !dev_doe, "R1 reset strobes",
        {dev_aen, dev_ior, dev_iow, dev_doe}, 0);
    rst_n = 1;
    exp_ptr = 16'h3000;

    do_check(exp_ptr, "after reset");

    run(1, 0, 16'h3FAB, 16'hC3A5, 0, rd, ok);
    shadow[6'h2B] = 16'hC3A5; exp_ptr = 16'h3FAB;
    do_check(exp_ptr, "nibble 3");

    run(1, 0, 16'h2FFF, 16'h1234, 0, rd, ok);
    shadow[6'h3F] = 16'h1234; exp_ptr = 16'h2FFF;
    do_check(exp_ptr, "nibble 2");

    run(0, 0, 16'h4000, 16'h0000, 0, rd, ok);
    chk(rd == shadow[0], "R3 read zero reg", rd, shadow[0]);
    exp_ptr = 16'h4000;
    do_check(exp_ptr, "nibble 4");

    // R5: same address twice, both rewrite the pointer
    run(0, 0, 16'h3FAB, 16'h0000, 0, rd, ok);
    chk(rd == 16'hC3A5, "R3 read back", rd, 16'hC3A5);
    run(0, 0, 16'h3FAB, 16'h0000, 0, rd, ok);
    chk(rd == 16'hC3A5, "R5 repeated read", rd, 16'hC3A5);
    exp_ptr = 16'h3FAB;

    // R11: both flags set is a check
    run(1, 1, 16'h0101, 16'hFFFF, 0, rd, ok);
    chk(rd == exp_ptr, "R11 check data", rd, exp_ptr);
    chk(shadow[1] == dmem[1], "R11 no write", dmem[1], shadow[1]);

    // R10: junk requests while busy
    run(1, 0, 16'h0005, 16'h5A5A, 8, rd, ok);
    shadow[5] = 16'h5A5A; exp_ptr = 16'h0005;
    run(0, 0, 16'h0005, 16'h0000, 0, rd, ok);
    chk(rd == 16'h5A5A, "R10 value intact", rd, 16'h5A5A);
    run(0, 0, 16'hFFFA, 16'h0000, 0, rd, ok);
    chk(rd == shadow[6'h3A], "R10 junk addr unwritten", rd, shadow[6'h3A]);
    exp_ptr = 16'hFFFA;

    for (int t = 0; t < 60; t++) begin
      automatic int op = int'($urandom % 3);
      automatic logic [15:0] a = 16'($urandom);
      automatic logic [15:0] d = 16'($urandom);
      if (op == 0) begin
        run(1, 0, a, d, 0, rd, ok);
        shadow[a[5:0]] = d; exp_ptr = a;
      end else if (op == 1) begin
        run(0, 0, a, 16'h0000, 0, rd, ok);
        chk(rd == shadow[a[5:0]], "R3 random read", rd, shadow[a[5:0]]);
        exp_ptr = a;
      end else begin
        do_check(exp_ptr, "random");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R9 actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule